// File: doc/BRIEF.md
# E1 Framer Periodic Status Generator

This block turns the periodic boundary events of an E1 framer into sticky flags that a host can poll or take as an interrupt. Four of the flags come from single-cycle strobes that mark the start of a receive multiframe, a receive align frame, a transmit multiframe and a transmit align frame. The multiframe flags fire on every boundary whether or not CAS signaling or CRC-4 is in use. The fifth flag comes from an internal timer clocked by the 2.048 MHz receive line clock. It fires once a second, or every 62.5 ms when the fast-timer mode bit is set.

The flags sit in one status byte. Reading the byte (a one-cycle read strobe) clears every flag. An event that arrives in the same cycle as the read wins over the clear, so no event is lost. An interrupt request is raised while any flag whose mask bit is 1 is set. The whole block runs in the receive clock domain, and the strobes are expected to be synchronous to it.

Top module: `e1stat_status_gen`

## Requirements
- R1: A receive multiframe strobe sampled at a clock edge sets status bit 7 after that edge.
- R2: A receive align frame strobe sets status bit 6 after the edge that samples it.
- R3: A transmit multiframe strobe sets status bit 4 after the edge that samples it.
- R4: A transmit align frame strobe sets status bit 3 after the edge that samples it.
- R5: With the fast mode bit at 0, the timer flag (status bit 5) is set after every CYC_PER_SEC-th clock edge counted from reset release, that is 2,048,000 cycles by default.
- R6: With the fast mode bit at 1, the timer flag is set after every (CYC_PER_SEC/FAST_DIV)-th edge, that is 128,000 cycles by default.
- R7: A set flag stays set for as long as no read strobe is sampled.
- R8: A read strobe sampled at an edge clears all flags after that edge. The value read is the status byte as it stood before that edge.
- R9: An event sampled at the same edge as a read strobe leaves its flag set after the edge.
- R10: Status bits 2 down to 0 always read as 0.
- R11: The interrupt output is 1 exactly when the status byte ANDed with the 8-bit mask input is nonzero.
- R12: While reset is asserted and right after its release, the status byte and the interrupt output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive line clock (2.048 MHz) |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_mf_stb | input | 1 | Receive multiframe boundary strobe |
| rx_af_stb | input | 1 | Receive align frame start strobe |
| tx_mf_stb | input | 1 | Transmit multiframe boundary strobe |
| tx_af_stb | input | 1 | Transmit align frame start strobe |
| fast_mode | input | 1 | 1 selects the 62.5 ms timer period |
| rd_stb | input | 1 | Host read of the status byte; clears all flags |
| irq_mask | input | 8 | Interrupt enable per status bit |
| status_o | output | 8 | Sticky status byte |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle the following: each strobe sets its own flag one edge later, flags hold when there is no read, a read with no event empties the byte, an event wins over a simultaneous read, the timer count stays inside its period, and the interrupt only rises when some flag is set. Some properties can only be shown by the bench scenarios. These are the exact timer periods in both modes counted from reset, the byte value the host sees at the moment of a read, the zero low bits, and the per-bit masking of the interrupt. The bench runs these with reduced timer parameters and compares each read against a queue of expected bytes.

// File: rtl/e1stat_pkg.sv
package e1stat_pkg;

    localparam int NUM_FLAGS = 5;
    localparam int FLAG_LSB  = 3;   // flags occupy status bits 7..3

    // index into the flag vector; index + FLAG_LSB = status bit
    typedef enum int {
        F_TXAF = 0,
        F_TXMF = 1,
        F_TICK = 2,
        F_RXAF = 3,
        F_RXMF = 4
    } flag_idx_e;

    typedef logic [NUM_FLAGS-1:0] flag_vec_t;

endpackage

// File: rtl/e1stat_sec_timer.sv
module e1stat_sec_timer #(
    parameter int CYC_NORM = 2048000,
    parameter int CYC_FAST = 128000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fast_mode,
    output logic tick
);
    localparam int CW = $clog2(CYC_NORM + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_d, st_q;
    logic [CW-1:0] last_cnt;

    always_comb begin
        st_d     = st_q;
        last_cnt = fast_mode ? CW'(CYC_FAST - 1) : CW'(CYC_NORM - 1);
        tick     = 1'b0;
        if (st_q.cnt >= last_cnt) begin
            tick       = 1'b1;
            st_d.cnt   = '0;
        end else begin
            st_d.cnt   = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: count never leaves the normal-mode period
    a_r5_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < CW'(CYC_NORM));

    // R6: after a fast-mode cycle the count sits inside the fast period
    a_r6_fast_range: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_mode && $past(fast_mode)) |-> (st_q.cnt < CW'(CYC_FAST)));

endmodule

// File: rtl/e1stat_flag_bank.sv
module e1stat_flag_bank
    import e1stat_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  flag_vec_t set_i,
    input  logic      clr_i,
    output flag_vec_t flags_o
);
    typedef struct packed {
        flag_vec_t flags;
    } bank_state_t;

    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_FLAGS; i++) begin
            // a new event takes priority over the read clear
            st_d.flags[i] = set_i[i] | (st_q.flags[i] & ~clr_i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && (set_i == '0)) |=> (flags_o == '0));

    a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((flags_o & $past(set_i)) == $past(set_i)));

endmodule

// File: rtl/e1stat_status_gen.sv
module e1stat_status_gen
    import e1stat_pkg::*;
#(
    parameter int CYC_PER_SEC = 2048000,
    parameter int FAST_DIV    = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_mf_stb,
    input  logic       rx_af_stb,
    input  logic       tx_mf_stb,
    input  logic       tx_af_stb,
    input  logic       fast_mode,
    input  logic       rd_stb,
    input  logic [7:0] irq_mask,
    output logic [7:0] status_o,
    output logic       irq_o
);
    localparam int CYC_FAST = CYC_PER_SEC / FAST_DIV;

    logic      tmr_tick;
    flag_vec_t events;
    flag_vec_t flags;

    e1stat_sec_timer #(
        .CYC_NORM (CYC_PER_SEC),
        .CYC_FAST (CYC_FAST)
    ) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .fast_mode (fast_mode),
        .tick      (tmr_tick)
    );

    always_comb begin
        events         = '0;
        events[F_RXMF] = rx_mf_stb;
        events[F_RXAF] = rx_af_stb;
        events[F_TICK] = tmr_tick;
        events[F_TXMF] = tx_mf_stb;
        events[F_TXAF] = tx_af_stb;
    end

    e1stat_flag_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (events),
        .clr_i   (rd_stb),
        .flags_o (flags)
    );

    assign status_o = {flags, {FLAG_LSB{1'b0}}};
    assign irq_o    = |(status_o & irq_mask);

    a_r1_rxmf_set: assert property (@(posedge clk) disable iff (!rst_n)
        rx_mf_stb |=> status_o[7]);
    a_r2_rxaf_set: assert property (@(posedge clk) disable iff (!rst_n)
        rx_af_stb |=> status_o[6]);
    a_r3_txmf_set: assert property (@(posedge clk) disable iff (!rst_n)
        tx_mf_stb |=> status_o[4]);
    a_r4_txaf_set: assert property (@(posedge clk) disable iff (!rst_n)
        tx_af_stb |=> status_o[3]);
    a_r11_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (status_o != 8'h00));

endmodule

// File: tb/sim_e1stat_status_gen.sv
module sim_e1stat_status_gen;

    localparam int SEC  = 400;
    localparam int FDIV = 8;
    localparam int FAST = SEC / FDIV;

    typedef struct {
        logic [7:0] exp;
        logic [7:0] care;
        string      req;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_mf = 1'b0, rx_af = 1'b0, tx_mf = 1'b0, tx_af = 1'b0;
    logic       fast = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] mask = 8'h00;
    logic [7:0] status;
    logic       irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;
    item_t sb[$];
    event chk_ev;

    always #10 clk = ~clk;   // 50 MHz

    e1stat_status_gen #(.CYC_PER_SEC(SEC), .FAST_DIV(FDIV)) u0 (
        .clk(clk), .rst_n(rst_n),
        .rx_mf_stb(rx_mf), .rx_af_stb(rx_af), .tx_mf_stb(tx_mf), .tx_af_stb(tx_af),
        .fast_mode(fast), .rd_stb(rd), .irq_mask(mask),
        .status_o(status), .irq_o(irq)
    );

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // monitor: pops the expected byte for each read and compares
    always @(chk_ev) begin
        item_t it;
        checks++;
        if (sb.size() == 0) begin
            errors++;
            $display("FAIL scoreboard empty: actual %02h expected none", status);
        end else begin
            it = sb.pop_front();
            if ((status & it.care) !== (it.exp & it.care)) begin
                errors++;
                $display("FAIL %s: actual %02h expected %02h (care %02h)",
                         it.req, status, it.exp, it.care);
            end
        end
    end

    task automatic check_direct(input logic [7:0] st_exp, input logic irq_exp, input string req);
        #2;
        checks++;
        if (status !== st_exp || irq !== irq_exp) begin
            errors++;
            $display("FAIL %s: actual status %02h irq %b expected status %02h irq %b",
                     req, status, irq, st_exp, irq_exp);
        end
    endtask

    // driver: read with optional strobes in the same cycle
    task automatic read_with(input logic [3:0] stb, input logic [7:0] exp,
                             input logic [7:0] care, input string req);
        item_t it;
        it.exp = exp; it.care = care; it.req = req;
        {rx_mf, rx_af, tx_mf, tx_af} = stb;
        rd = 1'b1;
        sb.push_back(it);
        #5 -> chk_ev;
        @(negedge clk);
        rd = 1'b0;
        {rx_mf, rx_af, tx_mf, tx_af} = 4'b0;
    endtask

    task automatic pulse(input logic [3:0] stb);
        {rx_mf, rx_af, tx_mf, tx_af} = stb;
        @(negedge clk);
        {rx_mf, rx_af, tx_mf, tx_af} = 4'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic do_reset(input logic fm);
        rst_n = 1'b0;
        fast  = fm;
        idle(3);
        rst_n = 1'b1;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    localparam logic [7:0] NOT_TMR = 8'hDF;

    initial begin
        @(negedge clk);
        do_reset(1'b0);
        check_direct(8'h00, 1'b0, "R12 reset");

        // R1 / R7 / R10 / R8
        pulse(4'b1000);
        idle(3);
        read_with(4'b0, 8'h80, NOT_TMR, "R1 R7 R10 rx multiframe");
        read_with(4'b0, 8'h00, NOT_TMR, "R8 cleared after read");
        // R2
        pulse(4'b0100);
        read_with(4'b0, 8'h40, NOT_TMR, "R2 rx align frame");
        // R3
        pulse(4'b0010);
        idle(2);
        read_with(4'b0, 8'h10, NOT_TMR, "R3 tx multiframe");
        // R4
        pulse(4'b0001);
        read_with(4'b0, 8'h08, NOT_TMR, "R4 tx align frame");
        // all strobes at once
        pulse(4'b1111);
        read_with(4'b0, 8'hD8, NOT_TMR, "R1 R2 R3 R4 together");
        read_with(4'b0, 8'h00, NOT_TMR, "R8 all cleared");
        // R9: event in the read cycle survives
        read_with(4'b0001, 8'h00, NOT_TMR, "R9 value before edge");
        read_with(4'b0, 8'h08, NOT_TMR, "R9 event kept");
        read_with(4'b1100, 8'h00, NOT_TMR, "R9 two events with read");
        read_with(4'b0, 8'hC0, NOT_TMR, "R9 both kept");

        // R11 interrupt masking
        pulse(4'b1000);
        mask = 8'h00; check_direct(8'h80, 1'b0, "R11 mask zero");
        mask = 8'h40; check_direct(8'h80, 1'b0, "R11 other bit masked");
        mask = 8'h87; check_direct(8'h80, 1'b1, "R11 bit enabled");
        @(negedge clk);
        read_with(4'b0, 8'h80, NOT_TMR, "R11 read");
        check_direct(8'h00, 1'b0, "R11 irq drops after read");
        mask = 8'h00;

        // R5 normal period
        wait_cyc(SEC - 1);
        read_with(4'b0, 8'h00, 8'h20, "R5 not yet at period-1");
        read_with(4'b0, 8'h20, 8'h20, "R5 set at period");
        wait_cyc(2 * SEC - 1);
        read_with(4'b0, 8'h00, 8'h20, "R5 not yet second period");
        read_with(4'b0, 8'h20, 8'h20, "R5 set second period");

        // R6 fast period after a fresh reset
        do_reset(1'b1);
        check_direct(8'h00, 1'b0, "R12 second reset");
        wait_cyc(FAST - 1);
        read_with(4'b0, 8'h00, 8'hFF, "R6 not yet fast period");
        read_with(4'b0, 8'h20, 8'hFF, "R6 set fast period");
        wait_cyc(2 * FAST - 1);
        read_with(4'b0, 8'h00, 8'hFF, "R6 not yet second fast");
        read_with(4'b0, 8'h20, 8'hFF, "R6 set second fast");

        idle(2);
        done = 1'b1;
        summary();
    end

endmodule